// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns an effective address into a real address by searching a hashed page table held in memory. The caller presents a 32-bit effective address, the segment register value that covers it, the privilege level and whether the access is a write. The walker then hashes the segment ID with the page index and reads the eight entries of the selected group one by one. If none of them matches, it does the same on a second group found from the complemented hash.

On a hit it works out read, write and execute rights from the protection key and the entry's protection code. It sets the referenced bit, and also the changed bit on a write, writing the entry's second word back only when that word actually changes. It then reports the real address and the entry's byte address. A read leaves the page without write permission, so the first write to a clean page comes back through the walker to mark it dirty.

Memory is reached through a single request/acknowledge port that carries one 32-bit word per transfer. The table base and the table mask are plain inputs.

Top module: `hpt_walker`

## Requirements
- R1: The primary group address is tbl_base + (((VSID XOR page index) << 6) AND tbl_mask). VSID is req_sr[23:0] and the page index is req_ea[27:12]. entry_addr reports the byte address of the matching entry, which is the group address + 8 × slot.
- R2: The slots are tested in ascending order. A slot matches when word0 bit 31 (valid) is 1, word0 bit 6 (secondary flag) equals the pass (0 primary, 1 secondary), word0[30:7] equals VSID and word0[5:0] equals req_ea[27:22]. The first matching slot wins, and found is 1.
- R3: Only after all eight primary slots miss does the walker search the group addressed by the bitwise complement of the 32-bit hash. If that search also misses, found=0 and perm=0, and no memory write occurs.
- R4: The protection key is req_sr[29] when req_user=1 and req_sr[30] when req_user=0.
- R5: perm is {read, write, execute}. With key 0, protection code word1[1:0] = 0, 1 or 2 gives read/write and 3 gives read only. With key 1, code 0 gives no rights, 1 and 3 give read only, and 2 gives read/write. Execute is granted unless req_sr[28] is 1.
- R6: On a hit the new second word is word1 with bit 8 (referenced) set, and also bit 7 (changed) set for a write. It is written to entry_addr+4 only if it differs from the old word.
- R7: When req_write=0, the write permission in perm is cleared.
- R8: real_addr = {word1[31:12], req_ea[11:0]}.
- R9: Each slot costs one read of word0 at the slot address and then one read of word1 at +4. A request stays asserted with a stable address and write enable until mem_ack.
- R10: A request is taken only while busy=0, and req_valid while busy=1 is ignored. done is a one-cycle pulse, after which busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_sr | input | 32 | Segment register: VSID [23:0], no-execute [28], user key [29], supervisor key [30] |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | 1 = user-mode access |
| req_write | input | 1 | 1 = write access |
| tbl_base | input | 32 | Byte base address of the page table |
| tbl_mask | input | 32 | Mask applied to the scaled hash |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Translation found |
| real_addr | output | 32 | Translated real address |
| perm | output | 3 | {read, write, execute} |
| entry_addr | output | 32 | Byte address of the matching entry |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer complete |

## Verification
The hardest situation to reach from the ports is a hit in the secondary group. It needs a primary group whose slots all fail for different reasons (an invalid entry, a wrong secondary flag, a wrong tag) and a secondary entry whose complemented hash lands on a chosen group. The bench gets there in two ways. Directed tables place such entries on purpose. For random walks, the bench picks a random stored entry and builds an effective address from it, choosing the page index low bits so that the hash, or its complement, selects that entry's group. The bench also varies the memory latency, so the hold-until-acknowledge rule is exercised with waits of zero to two cycles.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_READ0, S_READ1, S_CHECK, S_NEXT, S_WB, S_DONE
  } walk_state_t;

  localparam int PAGE_BITS = 12;
  localparam int VSID_W    = 24;
  localparam int PGIDX_W   = 16;
  localparam int API_W     = 6;
  // entry word bit positions
  localparam int PTE_VALID = 31;
  localparam int PTE_SEC   = 6;
  localparam int PTE_REF   = 8;
  localparam int PTE_CHG   = 7;
  // segment register bit positions
  localparam int SEG_KSUP  = 30;
  localparam int SEG_KUSR  = 29;
  localparam int SEG_NOEX  = 28;

  // compare tag laid out as the first word without valid and secondary bits
  function automatic logic [31:0] make_tag(input logic [VSID_W-1:0] vsid,
                                           input logic [API_W-1:0] api);
    return {1'b0, vsid, 1'b0, api};
  endfunction

  // rights {r,w,x} from key, protection code and no-execute
  function automatic logic [2:0] rights(input logic key, input logic [1:0] pp,
                                        input logic noex);
    logic r, w;
    if (!key) begin
      r = 1'b1;
      w = (pp != 2'd3);
    end else begin
      r = (pp != 2'd0);
      w = (pp == 2'd2);
    end
    return {r, w, ~noex};
  endfunction
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int AW          = 32,
  parameter int GROUP_SHIFT = 6
) (
  input  logic [VSID_W-1:0]  vsid,
  input  logic [PGIDX_W-1:0] pgidx,
  input  logic               secondary,
  input  logic [AW-1:0]      base,
  input  logic [AW-1:0]      mask,
  output logic [AW-1:0]      grp_addr,
  output logic [31:0]        tag
);
  logic [AW-1:0] hash, sel;

  always_comb begin
    hash     = AW'(vsid) ^ AW'(pgidx);
    sel      = secondary ? ~hash : hash;
    grp_addr = base + ((sel << GROUP_SHIFT) & mask);
    tag      = make_tag(vsid, pgidx[PGIDX_W-1 -: API_W]);
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
(
  input  logic [31:0] word0,
  input  logic [31:0] tag,
  input  logic        pass,
  output logic        hit
);
  logic [31:0] stripped;

  always_comb begin
    stripped = word0;
    stripped[PTE_VALID] = 1'b0;
    stripped[PTE_SEC]   = 1'b0;
    hit = word0[PTE_VALID] && (word0[PTE_SEC] == pass) && (stripped == tag);
  end
endmodule

// File: rtl/hpt_prot.sv
module hpt_prot
  import hpt_pkg::*;
(
  input  logic [31:0] word1,
  input  logic        user,
  input  logic        key_usr,
  input  logic        key_sup,
  input  logic        noex,
  input  logic        is_write,
  output logic [2:0]  perm,
  output logic [31:0] new_word1,
  output logic        wb_need
);
  always_comb begin
    perm = rights(user ? key_usr : key_sup, word1[1:0], noex);
    if (!is_write) perm[1] = 1'b0;
    new_word1 = word1;
    new_word1[PTE_REF] = 1'b1;
    if (is_write) new_word1[PTE_CHG] = 1'b1;
    wb_need = (new_word1 != word1);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int AW          = 32,
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   req_sr,
  input  logic [31:0]   req_ea,
  input  logic          req_user,
  input  logic          req_write,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] tbl_mask,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic [31:0]   real_addr,
  output logic [2:0]    perm,
  output logic [AW-1:0] entry_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack
);
  localparam int GROUP_SHIFT = $clog2(ENTRIES * ENTRY_BYTES);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam logic [AW-1:0] WORD1_OFF = AW'(ENTRY_BYTES / 2);

  walk_state_t        state;
  logic [VSID_W-1:0]  vsid_q;
  logic               ksup_q, kusr_q, noex_q, user_q, wr_q, pass_q;
  logic [27:0]        ea_q;
  logic [IDX_W-1:0]   idx_q;
  logic [31:0]        w0_q, w1_q;

  logic               found_q;
  logic [31:0]        raddr_q;
  logic [2:0]         perm_q;
  logic [AW-1:0]      entry_q;

  // named internal events
  logic [AW-1:0]      grp_addr_w, slot_addr_w;
  logic [31:0]        tag_w, new_w1_w;
  logic [2:0]         perm_w;
  logic               hit_w, wb_need_w, last_slot_w;
  logic               unused_bits;

  assign unused_bits = ^{req_sr[31], req_sr[27:24], req_ea[31:28]};

  hpt_hash #(.AW(AW), .GROUP_SHIFT(GROUP_SHIFT)) u_hash (
    .vsid(vsid_q), .pgidx(ea_q[27:PAGE_BITS]), .secondary(pass_q),
    .base(tbl_base), .mask(tbl_mask), .grp_addr(grp_addr_w), .tag(tag_w)
  );

  hpt_match u_match (.word0(w0_q), .tag(tag_w), .pass(pass_q), .hit(hit_w));

  hpt_prot u_prot (
    .word1(w1_q), .user(user_q), .key_usr(kusr_q), .key_sup(ksup_q),
    .noex(noex_q), .is_write(wr_q), .perm(perm_w), .new_word1(new_w1_w),
    .wb_need(wb_need_w)
  );

  assign slot_addr_w = grp_addr_w + (AW'(idx_q) << ENTRY_SHIFT);
  assign last_slot_w = (idx_q == IDX_W'(ENTRIES - 1));

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign mem_req   = (state == S_READ0) || (state == S_READ1) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_addr  = (state == S_READ0) ? slot_addr_w : slot_addr_w + WORD1_OFF;
  assign mem_wdata = new_w1_w;

  assign found      = found_q;
  assign real_addr  = raddr_q;
  assign perm       = perm_q;
  assign entry_addr = entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      vsid_q  <= '0;
      ksup_q  <= 1'b0;
      kusr_q  <= 1'b0;
      noex_q  <= 1'b0;
      user_q  <= 1'b0;
      wr_q    <= 1'b0;
      pass_q  <= 1'b0;
      ea_q    <= '0;
      idx_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      found_q <= 1'b0;
      raddr_q <= '0;
      perm_q  <= '0;
      entry_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          vsid_q <= req_sr[VSID_W-1:0];
          ksup_q <= req_sr[SEG_KSUP];
          kusr_q <= req_sr[SEG_KUSR];
          noex_q <= req_sr[SEG_NOEX];
          ea_q   <= req_ea[27:0];
          user_q <= req_user;
          wr_q   <= req_write;
          pass_q <= 1'b0;
          idx_q  <= '0;
          state  <= S_READ0;
        end
        S_READ0: if (mem_ack) begin
          w0_q  <= mem_rdata;
          state <= S_READ1;
        end
        S_READ1: if (mem_ack) begin
          w1_q  <= mem_rdata;
          state <= S_CHECK;
        end
        S_CHECK: begin
          if (hit_w) begin
            found_q <= 1'b1;
            raddr_q <= {w1_q[31:PAGE_BITS], ea_q[PAGE_BITS-1:0]};
            perm_q  <= perm_w;
            entry_q <= slot_addr_w;
            state   <= wb_need_w ? S_WB : S_DONE;
          end else begin
            state <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (!last_slot_w) begin
            idx_q <= idx_q + 1'b1;
            state <= S_READ0;
          end else if (!pass_q) begin
            pass_q <= 1'b1;
            idx_q  <= '0;
            state  <= S_READ0;
          end else begin
            found_q <= 1'b0;
            raddr_q <= '0;
            perm_q  <= '0;
            entry_q <= '0;
            state   <= S_DONE;
          end
        end
        S_WB:   if (mem_ack) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [31:0]   req_sr,
  input logic          busy,
  input logic          done,
  input logic          found,
  input logic [2:0]    perm,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata
);
  logic wr_l, nx_l;
  logic unused_chk;

  assign unused_chk = ^{req_sr[31:29], req_sr[27:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_l <= 1'b0;
      nx_l <= 1'b0;
    end else if (req_valid && !busy) begin
      wr_l <= req_write;
      nx_l <= req_sr[28];
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R6
  ref_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[8]);

  // R6
  dirty_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && wr_l |-> mem_wdata[7]);

  // R7
  write_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && perm[1] |-> wr_l);

  // R5
  noexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && nx_l |-> !perm[0]);

  // R3
  miss_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !found |-> perm == 3'b000);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind hpt_walker hpt_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] MASK = 32'h0000_0FC0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0;
  logic [31:0] req_sr = '0, req_ea = '0;
  logic        busy, done, found, mem_req, mem_we;
  logic [31:0] real_addr, entry_addr, mem_addr, mem_wdata;
  logic [2:0]  perm;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  logic [31:0] bmem [0:1023];
  int          lat_cnt = 0;
  int          rd_cnt = 0, wr_cnt = 0;
  int          total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sr(req_sr),
    .req_ea(req_ea), .req_user(req_user), .req_write(req_write),
    .tbl_base(BASE), .tbl_mask(MASK), .busy(busy), .done(done),
    .found(found), .real_addr(real_addr), .perm(perm),
    .entry_addr(entry_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  function automatic int ix(input logic [31:0] a);
    return int'((a - BASE) >> 2) & 1023;
  endfunction

  // memory with 0..2 cycles of random wait
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
      else begin
        mem_ack <= 1'b1;
        lat_cnt <= int'($urandom % 3);
        if (mem_we) begin
          bmem[ix(mem_addr)] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= bmem[ix(mem_addr)];
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // independent model of a walk over bench memory
  function automatic void model(input logic [31:0] sr, input logic [31:0] ea,
      input bit user, input bit wr, output bit f, output logic [31:0] ra,
      output logic [2:0] pm, output logic [31:0] ent, output logic [31:0] nw,
      output int nrd);
    logic [23:0] v = sr[23:0];
    logic [15:0] pg = ea[27:12];
    logic [31:0] h = {8'h00, v} ^ {16'h0000, pg};
    f = 0; ra = 0; pm = 0; ent = 0; nw = 0; nrd = 0;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 8; s++) begin
        if (!f) begin
          logic [31:0] hh = (p == 1) ? ~h : h;
          logic [31:0] a = BASE + ((hh * 64) & MASK) + 32'(s * 8);
          logic [31:0] w0 = bmem[ix(a)];
          logic [31:0] w1 = bmem[ix(a + 4)];
          nrd += 2;
          if (w0[31] && (w0[6] == p[0]) && w0[30:7] == v && w0[5:0] == pg[15:10]) begin
            bit key = user ? sr[29] : sr[30];
            bit r = !(key && w1[1:0] == 2'd0);
            bit w = key ? (w1[1:0] == 2'd2) : (w1[1:0] != 2'd3);
            f = 1;
            ent = a;
            ra = {w1[31:12], ea[11:0]};
            pm = {r, w && wr, !sr[28]};
            nw = w1 | 32'h100 | (wr ? 32'h80 : 32'h0);
          end
        end
      end
    end
  endfunction

  function automatic logic [31:0] grp(input logic [23:0] v, input logic [31:0] ea,
                                      input bit sec);
    logic [31:0] h = {8'h00, v} ^ {16'h0000, ea[27:12]};
    if (sec) h = ~h;
    return BASE + ((h * 64) & MASK);
  endfunction

  function automatic logic [31:0] pte0(input bit val, input logic [23:0] v,
                                       input bit sec, input logic [5:0] api);
    return {val, v, sec, api};
  endfunction

  function automatic logic [31:0] pte1(input logic [19:0] rpn, input bit r,
                                       input bit c, input logic [1:0] pp);
    return {rpn, 3'b000, r, c, 5'b00000, pp};
  endfunction

  function automatic logic [31:0] segr(input bit ks, input bit kp, input bit nx,
                                       input logic [23:0] v);
    return {1'b0, ks, kp, nx, 4'h0, v};
  endfunction

  task automatic clear_table();
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
  endtask

  task automatic put(input logic [31:0] g, input int slot, input logic [31:0] w0,
                     input logic [31:0] w1);
    bmem[ix(g + 32'(slot * 8))]     = w0;
    bmem[ix(g + 32'(slot * 8) + 4)] = w1;
  endtask

  // run one walk and compare everything with the model
  task automatic walk(input logic [31:0] sr, input logic [31:0] ea, input bit user,
                      input bit wr, input bit poke_busy);
    bit f; logic [31:0] ra, ent, nw; logic [2:0] pm; int nrd;
    int rd0, wr0, t;
    model(sr, ea, user, wr, f, ra, pm, ent, nw, nrd);
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_sr = sr; req_ea = ea; req_user = user; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      // R10: a second request during the walk must be ignored
      req_ea = ea ^ 32'h0FFF_F000; req_write = ~wr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(done === 1'b1, "R10 done", 32'(done), 32'd1);
    chk(found === f, "R2 found", 32'(found), 32'(f));
    chk(perm === pm, "R5 perm", 32'(perm), 32'(pm));
    chk(rd_cnt - rd0 == nrd, "R9 read count", 32'(rd_cnt - rd0), 32'(nrd));
    if (f) begin
      chk(real_addr === ra, "R8 real_addr", real_addr, ra);
      chk(entry_addr === ent, "R1 entry_addr", entry_addr, ent);
      chk(bmem[ix(ent + 4)] === nw, "R6 word1", bmem[ix(ent + 4)], nw);
    end else begin
      chk(wr_cnt == wr0, "R3 no write on miss", 32'(wr_cnt - wr0), 32'd0);
    end
    if (!wr) chk(perm[1] === 1'b0, "R7 write stripped", 32'(perm), 32'(pm));
    @(negedge clk);
    chk(!done && !busy, "R10 pulse", {30'd0, done, busy}, 32'd0);
  endtask

  // expected write count for a hit: one write only if word1 changes (R6)
  task automatic walk_wcount(input logic [31:0] sr, input logic [31:0] ea,
                             input bit user, input bit wr, input int exp_w);
    int w0 = wr_cnt;
    walk(sr, ea, user, wr, 1'b0);
    chk(wr_cnt - w0 == exp_w, "R6 write count", 32'(wr_cnt - w0), 32'(exp_w));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [23:0] pool [4];
    logic [23:0] v;
    logic [31:0] ea, g, sr;
    void'($urandom(32'd4242));
    pool[0] = 24'h000123; pool[1] = 24'h5A5A5A;
    pool[2] = 24'hFFFFF0; pool[3] = 24'h000000;
    clear_table();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R10 reset idle",
        {29'd0, busy, done, mem_req}, 32'd0);
    rst_n = 1'b1;

    // R1 R2 R7: primary slot 0, key 0, code 2, read -> r-x, R set, one write
    v = 24'h000123; ea = 32'h0ABC_D123;
    g = grp(v, ea, 0);
    put(g, 0, pte0(1, v, 0, ea[27:22]), pte1(20'h12345, 0, 0, 2'd2));
    sr = segr(0, 1, 0, v);
    walk_wcount(sr, ea, 0, 0, 1);
    // R6: same read again -> word unchanged, no write
    walk_wcount(sr, ea, 0, 0, 0);
    // R6: write -> C set, one write, rwx
    walk_wcount(sr, ea, 0, 1, 1);
    chk(perm === 3'b111, "R5 rwx on write", 32'(perm), 32'd7);

    // R2: slot 7 hit behind invalid, wrong-flag and wrong-tag entries
    clear_table();
    put(g, 0, pte0(0, v, 0, ea[27:22]), pte1(20'h1, 0, 0, 0));
    put(g, 1, pte0(1, v, 1, ea[27:22]), pte1(20'h2, 0, 0, 0));
    put(g, 2, pte0(1, v ^ 24'h1, 0, ea[27:22]), pte1(20'h3, 0, 0, 0));
    put(g, 3, pte0(1, v, 0, ea[27:22] ^ 6'h1), pte1(20'h4, 0, 0, 0));
    put(g, 7, pte0(1, v, 0, ea[27:22]), pte1(20'hABCDE, 1, 1, 2'd3));
    walk(sr, ea, 0, 0, 0);
    chk(entry_addr === g + 32'd56, "R2 slot 7 chosen", entry_addr, g + 32'd56);

    // R3: secondary hit; secondary flag required
    clear_table();
    put(grp(v, ea, 1), 3, pte0(1, v, 1, ea[27:22]), pte1(20'h0F0F0, 0, 0, 2'd1));
    walk(sr, ea, 0, 0, 0);
    chk(found === 1'b1 && entry_addr === grp(v, ea, 1) + 32'd24,
        "R3 secondary hit", entry_addr, grp(v, ea, 1) + 32'd24);

    // R3: both miss (entry in secondary group with flag 0)
    clear_table();
    put(grp(v, ea, 1), 0, pte0(1, v, 0, ea[27:22]), pte1(20'h1, 0, 0, 0));
    walk(sr, ea, 0, 0, 0);
    chk(found === 1'b0, "R3 miss", 32'(found), 32'd0);

    // R4 R5: user key selection with no-execute
    clear_table();
    put(g, 0, pte0(1, v, 0, ea[27:22]), pte1(20'h55555, 0, 0, 2'd0));
    walk(segr(0, 1, 1, v), ea, 1, 0, 0);
    chk(perm === 3'b000, "R4 user key1 code0 none", 32'(perm), 32'd0);
    walk(segr(0, 1, 1, v), ea, 0, 1, 0);
    chk(perm === 3'b110, "R4 supervisor key0 code0 rw", 32'(perm), 32'd6);
    put(g, 0, pte0(1, v, 0, ea[27:22]), pte1(20'h55555, 1, 1, 2'd2));
    walk(segr(1, 0, 0, v), ea, 0, 1, 0);
    chk(perm === 3'b111, "R4 supervisor key1 code2 rwx", 32'(perm), 32'd7);
    put(g, 0, pte0(1, v, 0, ea[27:22]), pte1(20'h55555, 1, 1, 2'd3));
    walk(segr(1, 0, 0, v), ea, 0, 1, 0);
    chk(perm === 3'b101, "R5 key1 code3 read only", 32'(perm), 32'd5);

    // R10: request while busy ignored
    walk(segr(1, 0, 0, v), ea, 0, 0, 1);

    // random table and requests
    for (int i = 0; i < 512; i++) begin
      logic [23:0] rv = pool[$urandom % 4];
      bmem[2*i]   = pte0(($urandom % 4) != 0, rv, $urandom % 2, 6'($urandom % 4));
      bmem[2*i+1] = $urandom;
    end
    for (int n = 0; n < 300; n++) begin
      logic [31:0] rsr, rea;
      if ($urandom % 2) begin
        int gi = int'($urandom % 64), si = int'($urandom % 8);
        logic [31:0] w0 = bmem[gi * 16 + si * 2];
        logic [5:0] low = (w0[6] ? ~6'(gi) : 6'(gi)) ^ w0[12:7];
        rea = {4'($urandom), w0[5:0], 4'($urandom), low, 12'($urandom)};
        rsr = {$urandom % 16, 4'($urandom), w0[30:7]};
      end else begin
        rea = {$urandom % 16, 10'(0), 2'($urandom), 16'($urandom)};
        rea = {rea[31:28], 6'($urandom % 4), 22'($urandom)};
        rsr = {4'($urandom), 4'($urandom), pool[$urandom % 4]};
      end
      walk(rsr, rea, $urandom % 2, $urandom % 2, ($urandom % 8) == 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule